// File: doc/BRIEF.md
# Trimmed Real-Time Clock Core with Alarm Status

This core keeps wall-clock time from a 32.768 kHz enable strobe. A trim prescaler counts the strobes and, once every N+1 of them, advances a 32-bit seconds counter. N is held in the low half of a trim register. After reset that register gives one seconds tick per second, and a lock bit can freeze it.

A seconds alarm compares the counter with an alarm value. Two day alarms compare a loadable day register with two alarm words. Each alarm has an enable bit and a sticky hit flag in a 16-bit status register. When the status register is written, a fixed mask picks the bits that take the written value. Every other bit is write-one-to-clear. A registered interrupt output is raised while any hit flag is set together with its enable. The day and year registers do not count: software loads them, and they keep only their packed calendar fields.

All registers sit on a simple word-addressed bus. A write is one cycle with select and write-enable high. Read data is combinational from the presented address.

Top module: `rtc_trim_core`

## Requirements
- R1: With trim divisor N in trim bits 15:0, the seconds counter advances by one on exactly every (N+1)th cycle in which `tick_32k_en` is high.
- R2: After reset the trim register (offset 0) reads 0x0000_7FFF and the status (offset 1) and seconds counter (offset 5) read zero, so 32768 strobes give the first increment.
- R3: While trim bit 31 is 1, writes to the trim register leave it unchanged.
- R4: The seconds alarm (value at offset 2) sets status bit 0 when the counter equals the alarm value, status bit 2 is 1 and bit 0 is still 0. The flag stays set until software clears it.
- R5: On a status write, the bits in mask 0xDAAC take the written value. Flag bits 0, 4 and 6 are cleared where the written data is 1 and kept where it is 0. All other status bits read 0.
- R6: Day alarm A (offset 3, enable bit 5, flag bit 4) and day alarm B (offset 4, enable bit 7, flag bit 6) set their flags when the day register equals the alarm word, under the same rule as R4.
- R7: A write to the seconds counter loads the written value and restarts the prescaler phase, so the next increment comes N+1 strobes after the write.
- R8: The day register (offset 6) keeps week-of-month in bits 22:20, day-of-week in 19:17, hour in 16:12, minute in 11:6 and second in 5:0. The year register (offset 7) keeps year in 20:9, month in 8:5 and day in 4:0. Other bits read 0.
- R9: `irq` equals, one cycle later, the OR over the three alarms of hit flag AND enable.
- R10: Reads of offsets 8 to 15 return zero and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k_en | input | 1 | One-cycle strobe at 32.768 kHz |
| bus_sel | input | 1 | Bus access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Registered alarm interrupt |

## Verification
The bench sweeps small divisors from 0 upward and counts strobes to the exact increment. A prescaler that is off by one would move the counter one strobe early or late. It reloads the counter in mid-phase. A design that kept the old phase would tick early. It writes all-ones and all-zeros to status while alarms are matching, to tell the direct bits apart from the clear-on-one flags. It also tries to rewrite a locked trim register, which a design with no lock would accept. The masked calendar fields and the unmapped reads are checked at the read port.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int ST_W   = 16;
  localparam int NUM_ALM = 3;

  localparam logic [ADDR_W-1:0] OFF_TRIM  = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 4'd1;
  localparam logic [ADDR_W-1:0] OFF_SALM  = 4'd2;
  localparam logic [ADDR_W-1:0] OFF_DALM0 = 4'd3;
  localparam logic [ADDR_W-1:0] OFF_SCNT  = 4'd5;
  localparam logic [ADDR_W-1:0] OFF_DAY   = 4'd6;
  localparam logic [ADDR_W-1:0] OFF_YEAR  = 4'd7;

  localparam logic [ST_W-1:0] ST_DIRECT = 16'hdaac;
  localparam logic [ST_W-1:0] ST_FLAGS  = 16'h0051;
  localparam logic [DATA_W-1:0] DAY_MASK  = 32'h007f_ffff;
  localparam logic [DATA_W-1:0] YEAR_MASK = 32'h001f_ffff;
  localparam logic [DATA_W-1:0] TRIM_RST  = 32'h0000_7fff;

  function automatic int hit_bit(input int idx);
    case (idx)
      0: return 0;
      1: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int en_bit(input int idx);
    case (idx)
      0: return 2;
      1: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] day_pack(input logic [2:0] wom, input logic [2:0] dow,
                                                 input logic [4:0] hr, input logic [5:0] mn,
                                                 input logic [5:0] sc);
    return {9'd0, wom, dow, hr, mn, sc};
  endfunction

  function automatic logic [DATA_W-1:0] year_pack(input logic [11:0] yr, input logic [3:0] mo,
                                                  input logic [4:0] dy);
    return {11'd0, yr, mo, dy};
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             clr,
  input  logic [PRE_W-1:0] div_n,
  output logic             sec_tick
);
  logic [PRE_W-1:0] cnt_q;

  assign sec_tick = tick_en && (cnt_q >= div_n);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr)        cnt_q <= '0;
    else if (sec_tick)   cnt_q <= '0;
    else if (tick_en)    cnt_q <= cnt_q + 1'b1;
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !clr) |=> (cnt_q == '0));
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !clr && !sec_tick) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_phase_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_status_unit.sv
module rtc_status_unit
  import rtc_trim_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ST_W-1:0]    wdata,
  input  logic [NUM_ALM-1:0] match,
  output logic [ST_W-1:0]    status,
  output logic               irq
);
  logic [ST_W-1:0] st_q, set_vec, base;
  logic            irq_d;

  always_comb begin
    set_vec = '0;
    irq_d   = 1'b0;
    for (int i = 0; i < NUM_ALM; i++) begin
      if (match[i] && st_q[en_bit(i)] && !st_q[hit_bit(i)]) set_vec[hit_bit(i)] = 1'b1;
      irq_d = irq_d | (st_q[en_bit(i)] & st_q[hit_bit(i)]);
    end
    base = wr_en ? ((wdata & ST_DIRECT) | (st_q & ST_FLAGS & ~wdata)) : st_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      irq  <= 1'b0;
    end else begin
      st_q <= base | set_vec;
      irq  <= irq_d;
    end
  end

  assign status = st_q;

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[0] && !wr_en) |=> st_q[0]);
  assert_direct_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((st_q & ST_DIRECT) == ($past(wdata) & ST_DIRECT)));
  assert_irq_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st_q & ST_FLAGS & (st_q >> 1)) || (st_q[6] && st_q[7])) |=> irq);
  assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !((st_q[0] && st_q[2]) || (st_q[4] && st_q[5]) || (st_q[6] && st_q[7])) |=> !irq);
endmodule

// File: rtl/rtc_trim_core.sv
module rtc_trim_core
  import rtc_trim_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int NUM_DALM = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k_en,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int LOCK_BIT = DATA_W - 1;

  logic [DATA_W-1:0] trim_q, salm_q, scnt_q, day_q, year_q;
  logic [DATA_W-1:0] dalm_q [NUM_DALM];
  logic [ST_W-1:0]   status;
  logic [NUM_ALM-1:0] match;
  logic wr, wr_trim, wr_scnt, wr_stat, sec_tick;

  assign wr      = bus_sel && bus_we;
  assign wr_trim = wr && (bus_addr == OFF_TRIM) && !trim_q[LOCK_BIT];
  assign wr_scnt = wr && (bus_addr == OFF_SCNT);
  assign wr_stat = wr && (bus_addr == OFF_STAT);

  rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_32k_en), .clr(wr_scnt),
    .div_n(trim_q[PRE_W-1:0]), .sec_tick(sec_tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trim_q <= TRIM_RST;
      salm_q <= '0;
      scnt_q <= '0;
      day_q  <= '0;
      year_q <= '0;
    end else begin
      if (wr_trim) trim_q <= bus_wdata;
      if (wr && bus_addr == OFF_SALM) salm_q <= bus_wdata;
      if (wr && bus_addr == OFF_DAY)  day_q  <= bus_wdata & DAY_MASK;
      if (wr && bus_addr == OFF_YEAR) year_q <= bus_wdata & YEAR_MASK;
      if (wr_scnt)       scnt_q <= bus_wdata;
      else if (sec_tick) scnt_q <= scnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_DALM; g++) begin : g_dalm
    always_ff @(posedge clk) begin
      if (!rst_n) dalm_q[g] <= '0;
      else if (wr && bus_addr == OFF_DALM0 + ADDR_W'(g)) dalm_q[g] <= bus_wdata & DAY_MASK;
    end
    assign match[g+1] = (day_q == dalm_q[g]);
  end
  assign match[0] = (scnt_q == salm_q);

  rtc_status_unit u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_stat), .wdata(bus_wdata[ST_W-1:0]),
    .match(match), .status(status), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_TRIM)                bus_rdata = trim_q;
    else if (bus_addr == OFF_STAT)           bus_rdata = {{(DATA_W-ST_W){1'b0}}, status};
    else if (bus_addr == OFF_SALM)           bus_rdata = salm_q;
    else if (bus_addr == OFF_DALM0)          bus_rdata = dalm_q[0];
    else if (bus_addr == OFF_DALM0 + 4'd1)   bus_rdata = dalm_q[NUM_DALM-1];
    else if (bus_addr == OFF_SCNT)           bus_rdata = scnt_q;
    else if (bus_addr == OFF_DAY)            bus_rdata = day_q;
    else if (bus_addr == OFF_YEAR)           bus_rdata = year_q;
  end

  assert_trim_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trim_q[LOCK_BIT] |=> $stable(trim_q));
  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_scnt && !sec_tick) |=> $stable(scnt_q));
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_scnt) |=> (scnt_q == $past(scnt_q) + 1'b1));
  assert_cnt_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_scnt |=> (scnt_q == $past(bus_wdata)));
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[3] |-> (bus_rdata == '0));
endmodule

// File: tb/rtc_trim_core_test.sv
module rtc_trim_core_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_trim_core uut (
    .clk(clk), .rst_n(rst_n), .tick_32k_en(tick), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    #1 chk(req, rdata, exp);
    @(posedge clk); #1 sel = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] da, db;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R2 reset values
    rd_chk("R2 trim reset", 4'd0, 32'h0000_7fff);
    rd_chk("R2 status reset", 4'd1, 32'h0);
    rd_chk("R2 counter reset", 4'd5, 32'h0);
    chk("R2 irq reset", {31'd0, irq}, 32'h0);
    pulses(32767);
    rd_chk("R2 no tick before 32768", 4'd5, 32'd0);
    pulses(1);
    rd_chk("R2 first second", 4'd5, 32'd1);

    // R1 divisor sweep, also R7 reload
    for (int n = 0; n < 6; n++) begin
      wr(4'd0, n);
      wr(4'd5, 32'd0);
      pulses(n);
      rd_chk("R1 before N+1 strobes", 4'd5, 32'd0);
      pulses(1);
      rd_chk("R1 at N+1 strobes", 4'd5, 32'd1);
      pulses(3 * (n + 1));
      rd_chk("R1 after 3 more periods", 4'd5, 32'd4);
    end

    // R4 seconds alarm, divisor 1
    wr(4'd0, 32'd1);
    wr(4'd2, 32'd3);
    wr(4'd5, 32'd2);
    wr(4'd1, 32'h0004);
    pulses(1);
    idle(2);
    rd_chk("R4 no hit before match", 4'd1, 32'h0004);
    pulses(1);
    idle(2);
    rd_chk("R4 hit flag set", 4'd1, 32'h0005);
    chk("R9 irq on enabled hit", {31'd0, irq}, 32'h1);
    // R5 writing 0 to a flag keeps it
    wr(4'd1, 32'h0004);
    idle(1);
    rd_chk("R5 flag kept on write 0", 4'd1, 32'h0005);
    wr(4'd1, 32'h0001);
    idle(2);
    rd_chk("R5 flag cleared on write 1", 4'd1, 32'h0000);
    chk("R9 irq drops", {31'd0, irq}, 32'h0);
    // R5 all-ones: direct bits take value, then all alarms match
    wr(4'd1, 32'hffff_ffff);
    idle(2);
    rd_chk("R5 R6 all ones", 4'd1, 32'h0000_dafd);
    wr(4'd1, 32'h0);
    idle(1);
    rd_chk("R5 zeros keep flags", 4'd1, 32'h0000_0051);
    idle(1);
    chk("R9 flags without enables", {31'd0, irq}, 32'h0);
    wr(4'd1, 32'h0000_0051);
    idle(1);
    rd_chk("R5 clear all flags", 4'd1, 32'h0);

    // R6 day alarms
    da = (32'd1 << 20) | (32'd2 << 17) | (32'd3 << 12) | (32'd4 << 6) | 32'd5;
    db = (32'd4 << 20) | (32'd7 << 17) | (32'd23 << 12) | (32'd59 << 6) | 32'd58;
    wr(4'd3, da);
    wr(4'd4, db);
    rd_chk("R6 alarm A readback", 4'd3, da);
    wr(4'd1, 32'h00a0);
    idle(2);
    rd_chk("R6 no day match", 4'd1, 32'h00a0);
    wr(4'd6, da);
    idle(2);
    rd_chk("R6 alarm A hit", 4'd1, 32'h00b0);
    chk("R9 irq day hit", {31'd0, irq}, 32'h1);
    wr(4'd6, db);
    idle(2);
    rd_chk("R6 alarm B hit", 4'd1, 32'h00f0);
    wr(4'd1, 32'h0050);
    idle(2);
    rd_chk("R6 flags cleared", 4'd1, 32'h0);

    // R8 field packing
    wr(4'd6, 32'hffff_ffff);
    rd_chk("R8 day mask", 4'd6, 32'h007f_ffff);
    wr(4'd7, 32'hffff_ffff);
    rd_chk("R8 year mask", 4'd7, 32'h001f_ffff);
    wr(4'd7, (32'd2024 << 9) | (32'd6 << 5) | 32'd15);
    rd_chk("R8 year fields", 4'd7, 32'h000f_d0cf);

    // R3 lock
    wr(4'd0, 32'h8000_0002);
    rd_chk("R3 lock write", 4'd0, 32'h8000_0002);
    wr(4'd0, 32'h0000_0005);
    rd_chk("R3 locked ignores write", 4'd0, 32'h8000_0002);
    wr(4'd5, 32'd100);
    pulses(2);
    rd_chk("R3 divisor kept", 4'd5, 32'd100);
    pulses(1);
    rd_chk("R3 divisor 2 tick", 4'd5, 32'd101);

    // R7 phase restart
    pulses(2);
    wr(4'd5, 32'd50);
    rd_chk("R7 reload value", 4'd5, 32'd50);
    pulses(2);
    rd_chk("R7 phase restarted", 4'd5, 32'd50);
    pulses(1);
    rd_chk("R7 tick after N+1", 4'd5, 32'd51);

    // R10 unmapped reads
    wr(4'd1, 32'h0000_0800);
    for (int a = 8; a < 16; a++) rd_chk("R10 unmapped zero", 4'(a), 32'h0);
    rd_chk("R10 status untouched", 4'd1, 32'h0000_0800);
    rd_chk("R10 counter untouched", 4'd5, 32'd51);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule